// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A clocked single-port word memory for a processor's external cache. Each word is 18 bits, made of two 9-bit byte lanes (eight data bits plus one parity bit per lane). An access can be opened by either of two address strobes. The processor-side strobe is gated by the first chip select. The controller-side strobe is not. Once a burst is open, a step input walks the two low address bits through a four-beat group, in linear or interleaved order.

Read data is registered. It is driven on `rdata` in the cycle that follows the accepted access, and the output enable lets it through. A sleep request is synchronised over two clock edges. While the block is asleep, and for a fixed recovery window after it wakes, no access is accepted. The memory contents are kept, and any open burst is dropped.

The address width is a parameter. The default is kept small for elaboration; full size is `ADDR_W = 18`.

Top module: `burst_cache_sram`

## Requirements
- R1: With `wr_all_n` low on an accepted controller-started or continuing beat, all 18 bits of `wdata` are written to the beat address.
- R2: With `wr_all_n` high and `wr_lane_en_n` low, bit 0 of `lane_sel_n` (active low) writes bits 8:0 and bit 1 writes bits 17:9. With both write controls high, nothing is written and the beat is a read.
- R3: A read accepted at a clock edge shows the addressed word on `rdata`, with `rdata_drive` high, until the next edge. While `out_en_n` is high, `rdata` is zero and `rdata_drive` is low.
- R4: A start captures `addr`. Every beat of the burst keeps the captured upper bits, and the first beat uses the captured low two bits `s`.
- R5: With `lin_order` high, beat k uses low bits (s + k) mod 4.
- R6: With `lin_order` low, which is the tie-off default, beat k uses low bits s XOR k.
- R7: On a cycle with no strobe and a burst open, a low `step_n` advances the beat counter and accesses the next address. A high `step_n` repeats the current address. The counter wraps after four beats.
- R8: `cpu_strobe_n` is ignored while `sel_a_n` is high. `ctl_strobe_n` is still sampled on such a cycle. When both strobes are valid, the processor strobe wins.
- R9: A beat started by the processor strobe is always a read, whatever the write controls are.
- R10: A start is accepted only with `sel_a_n` low, `sel_b` high and `sel_c_n` low. A valid strobe with any select inactive closes the burst and makes no access.
- R11: `asleep` rises on the second edge after `sleep_req` goes high and falls on the second edge after it goes low. While `asleep` is high, no access is made and the open burst is cancelled.
- R12: For `RECOV_CYC` cycles after `asleep` falls, strobes and steps are ignored.
- R13: After reset, `rdata_drive` and `asleep` are low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on a start |
| cpu_strobe_n | input | 1 | Processor-side start strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low |
| lin_order | input | 1 | High: linear order; low: interleaved order |
| out_en_n | input | 1 | Output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Registered read data, zero when not driven |
| rdata_drive | output | 1 | High when `rdata` carries valid read data |
| asleep | output | 1 | Sleep state after synchronisation |

## Verification
Two functions can act in the same cycle. One is the gating of the processor strobe by select A. The other is the advance of an open burst. The bench drives the processor strobe with select A inactive and a step in the same cycle, and expects the next sequential word, which shows that the burst went on. It also drives both strobes together with the write controls active, and expects the old word back with the memory unchanged. A sleep request raised in the middle of a burst is judged the same way: suspended reads continue until `asleep` rises, and the burst is gone after recovery.

// File: rtl/burst_cache_sram.sv
module burst_cache_sram #(
  parameter int ADDR_W    = 10,
  parameter int RECOV_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              step_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [1:0]        lane_sel_n,
  input  logic              lin_order,
  input  logic              out_en_n,
  input  logic              sleep_req,
  input  logic [17:0]       wdata,
  output logic [17:0]       rdata,
  output logic              rdata_drive,
  output logic              asleep
);
  localparam int LANE_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RW     = $clog2(RECOV_CYC + 1);

  logic [2*LANE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q;
  logic              z1_q, z2_q;
  logic [RW-1:0]     rcnt_q;
  logic [17:0]       rd_q;
  logic              rd_vld_q;

  logic blocked, chip_on, cpu_go, ctl_go, strobe, start, cont, access;
  logic [1:0] start_bits, cnt_nx, low, wr_lanes;
  logic [ADDR_W-3:0] hi;
  logic [ADDR_W-1:0] acc_addr;
  logic do_read;

  assign blocked    = z2_q | (rcnt_q != '0);
  assign chip_on    = !sel_a_n & sel_b & !sel_c_n;
  assign cpu_go     = !cpu_strobe_n & !sel_a_n;
  assign ctl_go     = !ctl_strobe_n & !cpu_go;
  assign strobe     = cpu_go | ctl_go;
  assign start      = strobe & chip_on & !blocked;
  assign cont       = !strobe & active_q & !blocked;
  assign access     = start | cont;

  assign start_bits = start ? addr[1:0] : base_q[1:0];
  assign hi         = start ? addr[ADDR_W-1:2] : base_q[ADDR_W-1:2];
  assign cnt_nx     = start ? 2'd0 : cnt_q + {1'b0, !step_n};
  assign low        = lin_order ? start_bits + cnt_nx : start_bits ^ cnt_nx;
  assign acc_addr   = {hi, low};

  always_comb begin
    if (start && cpu_go)      wr_lanes = 2'b00;
    else if (!wr_all_n)       wr_lanes = 2'b11;
    else if (!wr_lane_en_n)   wr_lanes = ~lane_sel_n;
    else                      wr_lanes = 2'b00;
  end

  assign do_read     = access & (wr_lanes == 2'b00);
  assign asleep      = z2_q;
  assign rdata_drive = rd_vld_q & !out_en_n;
  assign rdata       = rdata_drive ? rd_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z1_q     <= 1'b0;
      z2_q     <= 1'b0;
      rcnt_q   <= '0;
      active_q <= 1'b0;
      cnt_q    <= 2'd0;
      base_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      z1_q <= sleep_req;
      z2_q <= z1_q;
      if (z2_q && !z1_q)       rcnt_q <= RW'(RECOV_CYC);
      else if (rcnt_q != '0)   rcnt_q <= rcnt_q - RW'(1);
      if (blocked)             active_q <= 1'b0;
      else if (strobe)         active_q <= chip_on;
      if (access)              cnt_q <= cnt_nx;
      if (start)               base_q <= addr;
      rd_vld_q <= do_read;
    end
  end

  always_ff @(posedge clk) begin
    if (access && wr_lanes[0]) mem[acc_addr][LANE_W-1:0]        <= wdata[LANE_W-1:0];
    if (access && wr_lanes[1]) mem[acc_addr][2*LANE_W-1:LANE_W] <= wdata[2*LANE_W-1:LANE_W];
    if (do_read)               rd_q <= mem[acc_addr];
  end
endmodule

// File: rtl/burst_cache_sram_chk.sv
module burst_cache_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_strobe_n,
  input logic       ctl_strobe_n,
  input logic       sel_a_n,
  input logic       step_n,
  input logic       sleep_req,
  input logic       asleep,
  input logic       rdata_drive,
  input logic       active_q,
  input logic       start,
  input logic       cont,
  input logic [1:0] cnt_q
);
  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_req, 2));
  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> !rdata_drive);
  // R12
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !rdata_drive);
  // R8
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && ctl_strobe_n && (cpu_strobe_n || sel_a_n)) |=> !rdata_drive);
  // R7
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !step_n) |=> cnt_q == $past(cnt_q) + 2'd1);
  // R7
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && step_n) |=> $stable(cnt_q));
  // R4
  start_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == 2'd0);
endmodule

bind burst_cache_sram burst_cache_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
  .sel_a_n(sel_a_n), .step_n(step_n), .sleep_req(sleep_req), .asleep(asleep),
  .rdata_drive(rdata_drive), .active_q(active_q), .start(start), .cont(cont), .cnt_q(cnt_q)
);

// File: tb/burst_cache_sram_tb.sv
module burst_cache_sram_tb_top;
  localparam int AW = 6;
  localparam int RC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic cpu_strobe_n, ctl_strobe_n, step_n, sel_a_n, sel_b, sel_c_n;
  logic wr_all_n, wr_lane_en_n, lin_order, out_en_n, sleep_req;
  logic [1:0] lane_sel_n;
  logic [17:0] wdata, rdata;
  logic rdata_drive, asleep;

  logic [17:0] exp_mem [1<<AW];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  burst_cache_sram #(.ADDR_W(AW), .RECOV_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .step_n(step_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_sel_n(lane_sel_n), .lin_order(lin_order), .out_en_n(out_en_n),
    .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive),
    .asleep(asleep)
  );

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = 2'b11; out_en_n = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic see(input int a, input string req);
    chk(rdata_drive === 1'b1 && rdata === exp_mem[a], req, rdata, exp_mem[a]);
  endtask

  task automatic see_none(input string req);
    chk(rdata_drive === 1'b0 && rdata === 18'd0, req, rdata, 18'd0);
  endtask

  task automatic ctl_write(input int a, input logic [17:0] d);
    idle(); addr = AW'(a); ctl_strobe_n = 0; wr_all_n = 0; wdata = d; cyc();
    exp_mem[a] = d; idle();
  endtask

  task automatic open_read(input int a, input bit use_cpu, input string req);
    idle(); addr = AW'(a);
    if (use_cpu) cpu_strobe_n = 0; else ctl_strobe_n = 0;
    cyc(); see(a, req); idle();
  endtask

  task automatic step_read(input int a, input string req);
    idle(); step_n = 0; cyc(); see(a, req); idle();
  endtask

  initial begin
    #(10*150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 18'd1, 18'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(); addr = '0; wdata = '0; lin_order = 0; sleep_req = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(rdata_drive === 1'b0, "R13", {17'd0, rdata_drive}, 18'd0);
    chk(asleep === 1'b0, "R13", {17'd0, asleep}, 18'd0);
    rst_n = 1; cyc();
    idle(); step_n = 0; cyc(); see_none("R13 no burst after reset");

    // R1 fill whole array then read back every word
    for (int a = 0; a < (1<<AW); a++) ctl_write(a, 18'((a*4099 + 677) ^ (a << 11)));
    for (int a = 0; a < (1<<AW); a++) open_read(a, 1'b0, "R1");

    // R4 R5 R6 burst order sweep
    for (int lin = 0; lin < 2; lin++) begin
      for (int g = 0; g < 16; g += 5) begin
        for (int s = 0; s < 4; s++) begin
          lin_order = lin[0];
          open_read(g*4 + s, s[0], "R4");
          for (int k = 1; k <= 4; k++) begin
            int lo;
            lo = lin ? ((s + k) & 3) : (s ^ (k & 3));
            step_read(g*4 + lo, lin ? "R5" : "R6");
          end
        end
      end
    end

    // R7 suspend repeats, then advance
    lin_order = 1;
    open_read(9, 1'b1, "R7");
    idle(); cyc(); see(9, "R7 suspend");
    step_read(10, "R7 advance");

    // R2 lane writes
    for (int ls = 0; ls < 4; ls++) begin
      int a;
      logic [17:0] nv;
      a = 20 + ls;
      nv = ~exp_mem[a] ^ 18'h1234;
      idle(); addr = AW'(a); ctl_strobe_n = 0; wr_lane_en_n = 0; lane_sel_n = 2'(ls); wdata = nv;
      cyc();
      if (!ls[0]) exp_mem[a][8:0]  = nv[8:0];
      if (!ls[1]) exp_mem[a][17:9] = nv[17:9];
      open_read(a, 1'b0, "R2 lane merge");
    end
    idle(); addr = AW'(30); ctl_strobe_n = 0; lane_sel_n = 2'b00; wdata = ~exp_mem[30]; cyc();
    see(30, "R2 no write without enables");
    open_read(30, 1'b0, "R2 unchanged");

    // R9 processor-started beat is a read
    idle(); addr = AW'(40); cpu_strobe_n = 0; wr_all_n = 0; wdata = ~exp_mem[40]; cyc();
    see(40, "R9 read first beat");
    open_read(40, 1'b0, "R9 unchanged");

    // R8 gated processor strobe during burst advance
    open_read(44, 1'b1, "R8");
    idle(); cpu_strobe_n = 0; sel_a_n = 1; step_n = 0; cyc();
    see(45, "R8 ignored strobe, burst advanced");
    idle(); ctl_strobe_n = 0; sel_a_n = 1; cyc(); see_none("R8 controller strobe deselects");
    idle(); step_n = 0; cyc(); see_none("R8 burst closed");
    idle(); addr = AW'(47); cpu_strobe_n = 0; ctl_strobe_n = 0; wr_all_n = 0; wdata = ~exp_mem[47]; cyc();
    see(47, "R8 priority read");
    open_read(47, 1'b0, "R8 unchanged");

    // R10 selection
    idle(); addr = AW'(33); ctl_strobe_n = 0; sel_b = 0; wr_all_n = 0; wdata = 18'h0; cyc();
    see_none("R10 sel_b low");
    idle(); addr = AW'(33); ctl_strobe_n = 0; sel_c_n = 1; wr_all_n = 0; wdata = 18'h0; cyc();
    see_none("R10 sel_c high");
    open_read(33, 1'b0, "R10 unchanged");

    // R3 output enable
    idle(); addr = AW'(12); ctl_strobe_n = 0; out_en_n = 1; cyc();
    see_none("R3 output disabled");
    idle(); out_en_n = 0; cyc(); see(12, "R3 enabled suspend read");

    // R11 R12 sleep
    open_read(50, 1'b1, "R11");
    idle(); sleep_req = 1; cyc();
    chk(asleep === 1'b0, "R11 one edge", {17'd0, asleep}, 18'd0);
    cyc();
    chk(asleep === 1'b1, "R11 two edges", {17'd0, asleep}, 18'd1);
    idle(); addr = AW'(51); ctl_strobe_n = 0; wr_all_n = 0; wdata = ~exp_mem[51]; cyc();
    see_none("R11 access blocked");
    idle(); sleep_req = 0; cyc();
    chk(asleep === 1'b1, "R11 exit one edge", {17'd0, asleep}, 18'd1);
    cyc();
    chk(asleep === 1'b0, "R11 exit two edges", {17'd0, asleep}, 18'd0);
    idle(); addr = AW'(52); ctl_strobe_n = 0; wr_all_n = 0; wdata = ~exp_mem[52]; cyc();
    see_none("R12 recovery strobe");
    idle(); step_n = 0; cyc(); see_none("R12 recovery step");
    idle(); step_n = 0; cyc(); see_none("R11 burst cancelled");
    open_read(51, 1'b0, "R11 contents kept");
    open_read(52, 1'b0, "R12 contents kept");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule